// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

The arbiter sits between seven interrupt request lines and a CPU core. The lines are two external interrupts, three timer overflows, a serial port and a capture/compare array. A byte-wide enable register holds one enable bit per source and a master gate. Two further byte-wide registers hold an upper and a lower priority bit for each source. Together they give every source one of four levels.

Every cycle the arbiter looks at the pending, enabled requests and chooses one winner. The highest level wins first. Within that level the winner is the source that comes first in a fixed polling order. The choice is offered to the CPU as a registered request strobe and a 3-bit source number. That offer is re-evaluated on every cycle until the CPU acknowledges it.

An acknowledge records the granted level in a four-bit in-service mask. A return-from-interrupt pulse retires the most recent, highest level in that mask. While a handler is running, a new offer is made only for a level strictly above the highest level in service. This is how nested preemption works.

Top module: `nest_irq_arbiter`

## Requirements
- R1: The register port writes synchronously and reads combinationally. Address 0 is the enable register, address 1 holds the upper priority bits and address 2 holds the lower priority bits. Address 3 reads as zero. All registers reset to zero. Bit 7 of both priority registers is not stored and reads as 0.
- R2: While enable bit 7 (the master gate) is 0, `int_req` stays low whatever the per-source enables and pending lines are.
- R3: While the master gate is 1, a source takes part in arbitration only if its enable bit is 1 and its pending line is high.
- R4: A source's level is {upper bit, lower bit}, from 0 (lowest) to 3 (highest). Among the pending, enabled sources the highest level is offered.
- R5: When several such sources share the highest level, the one with the smallest source number wins. This is the polling order: external 0, timer 0, external 1, timer 1, serial port, timer 2, capture array.
- R6: While handlers are in service, a source is offered only if its level is strictly above the highest in-service level. A source at an equal or lower level waits.
- R7: While level 3 is in service, no request is offered.
- R8: When `int_ack` is high with `int_req` high, the presented level's bit in `in_service` is set at that edge. `int_req` is low in the following cycle.
- R9: An `int_reti` pulse clears the highest set bit of `in_service`. A pulse when the mask is empty does nothing.
- R10: `int_req` and `int_src` are registered. They appear one clock after the inputs that cause them and are re-chosen every cycle without an acknowledge, so a later higher-level request replaces the current offer.
- R11: `int_src` and bit positions 0..6 of all three registers use the same source numbering: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial port, 5 timer 2, 6 capture array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 7 | Pending request per source, indexed by source number |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 upper priority, 2 lower priority) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| int_req | output | 1 | Interrupt offered to the CPU |
| int_src | output | 3 | Source number of the offered interrupt |
| int_ack | input | 1 | CPU takes the offered interrupt |
| int_reti | input | 1 | CPU returns from the current handler |
| in_service | output | 4 | In-service mask, one bit per level |

## Verification
The hardest situation to reach is arbitration under a partly filled in-service mask. Levels only enter that mask through a full offer-and-acknowledge handshake. To get there, the bench first programs every source to one level, presents a single request and acknowledges it, which places exactly that level in service. It then sweeps all 128 pending patterns under shuffled priorities and enables. A separate sequence builds three nested levels through three acknowledges and unwinds them one return pulse at a time.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int NSRC   = 7;
  localparam int NLVL   = 4;
  localparam int LVL_W  = $clog2(NLVL);
  localparam int IDX_W  = $clog2(NSRC + 1);
  localparam int RANK_W = $clog2(NLVL + 1);
  localparam int REG_W  = 8;
  localparam int GATE_BIT = REG_W - 1;

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_PRI_HI = 2'd1;
  localparam logic [1:0] ADDR_PRI_LO = 2'd2;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [RANK_W-1:0] rank_t;

  // Level of source i, upper bit from the high register.
  function automatic lvl_t src_level(input logic [NSRC-1:0] hi,
                                     input logic [NSRC-1:0] lo,
                                     input int i);
    return {hi[i], lo[i]};
  endfunction

  // 0 when nothing is in service, otherwise highest level + 1.
  function automatic rank_t svc_rank(input logic [NLVL-1:0] m);
    rank_t r;
    r = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (m[i]) r = rank_t'(i + 1);
    end
    return r;
  endfunction

  // Mask with its highest set bit removed.
  function automatic logic [NLVL-1:0] drop_top(input logic [NLVL-1:0] m);
    logic [NLVL-1:0] r;
    logic done;
    r = m;
    done = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (m[i] && !done) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] enable_q,
  output logic [NSRC-1:0]  pri_hi_q,
  output logic [NSRC-1:0]  pri_lo_q
);

  localparam int PAD = REG_W - NSRC;

  logic wr_enable, wr_hi, wr_lo;
  assign wr_enable = wr_en && (addr == ADDR_ENABLE);
  assign wr_hi     = wr_en && (addr == ADDR_PRI_HI);
  assign wr_lo     = wr_en && (addr == ADDR_PRI_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      pri_hi_q <= '0;
      pri_lo_q <= '0;
    end else begin
      if (wr_enable) enable_q <= wdata;
      if (wr_hi)     pri_hi_q <= wdata[NSRC-1:0];
      if (wr_lo)     pri_lo_q <= wdata[NSRC-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADDR_ENABLE: rdata = enable_q;
      ADDR_PRI_HI: rdata = {{PAD{1'b0}}, pri_hi_q};
      ADDR_PRI_LO: rdata = {{PAD{1'b0}}, pri_lo_q};
      default:     rdata = '0;
    endcase
  end

  AST_ENABLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> enable_q == $past(wdata)); // R1
  AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> pri_hi_q == $past(wdata[NSRC-1:0])); // R1
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(enable_q) && $stable(pri_hi_q) && $stable(pri_lo_q)); // R1

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic [REG_W-1:0] enable_q,
  input  logic [NSRC-1:0]  pri_hi_q,
  input  logic [NSRC-1:0]  pri_lo_q,
  input  rank_t            rank,
  output logic             found,
  output idx_t             win_idx,
  output lvl_t             win_lvl
);

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] cand [NLVL];
  logic [NSRC-1:0] win_vec;

  assign live = pend & enable_q[NSRC-1:0] & {NSRC{enable_q[GATE_BIT]}};

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign cand[l][i] = live[i] && (src_level(pri_hi_q, pri_lo_q, i) == lvl_t'(l));
    end
  end

  // Ascending scan: the highest eligible level overwrites lower ones.
  always_comb begin
    found   = 1'b0;
    win_lvl = '0;
    win_vec = '0;
    for (int l = 0; l < NLVL; l++) begin
      if ((|cand[l]) && ((l + 1) > int'(rank))) begin
        found   = 1'b1;
        win_lvl = lvl_t'(l);
        win_vec = cand[l];
      end
    end
  end

  // Descending scan: the first source in polling order wins.
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (win_vec[i]) win_idx = idx_t'(i);
    end
  end

  AST_WINNER_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pend[win_idx] && enable_q[win_idx] && enable_q[GATE_BIT]); // R3
  AST_WINNER_FIRST_POLLED: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((live & ((NSRC'(1) << win_idx) - NSRC'(1))) &
               ~(pri_hi_q ^ {NSRC{win_lvl[1]}}) & ~(pri_lo_q ^ {NSRC{win_lvl[0]}})) == '0); // R5
  AST_NO_HIGHER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (found && win_lvl != lvl_t'(NLVL - 1)) |-> cand[NLVL-1] == '0); // R4

endmodule

// File: rtl/irq_arb_service.sv
module irq_arb_service
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_fire,
  input  lvl_t            ack_lvl,
  input  logic            reti,
  output logic [NLVL-1:0] mask_q,
  output rank_t           rank
);

  logic [NLVL-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (reti)     mask_d = drop_top(mask_q);
    if (ack_fire) mask_d[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rank = svc_rank(mask_q);

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> mask_q[$past(ack_lvl)]); // R8
  AST_RETI_REMOVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack_fire && mask_q != '0) |=>
      ($countones(mask_q) + 1 == $countones($past(mask_q))) &&
      ((mask_q & ~$past(mask_q)) == '0)); // R9
  AST_RETI_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack_fire) |=> svc_rank(mask_q) < $past(rank) || $past(rank) == '0); // R9

endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_pend,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             int_req,
  output logic [IDX_W-1:0] int_src,
  input  logic             int_ack,
  input  logic             int_reti,
  output logic [NLVL-1:0]  in_service
);

  logic [REG_W-1:0] enable_q;
  logic [NSRC-1:0]  pri_hi_q, pri_lo_q;
  logic             found;
  idx_t             win_idx;
  lvl_t             win_lvl;
  rank_t            rank;
  logic             ack_fire;
  logic             req_q;
  idx_t             idx_q;
  lvl_t             lvl_q;

  irq_arb_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .enable_q (enable_q),
    .pri_hi_q (pri_hi_q),
    .pri_lo_q (pri_lo_q)
  );

  irq_arb_select i_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (irq_pend),
    .enable_q (enable_q),
    .pri_hi_q (pri_hi_q),
    .pri_lo_q (pri_lo_q),
    .rank     (rank),
    .found    (found),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign ack_fire = int_ack && req_q;

  irq_arb_service i_service (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_fire (ack_fire),
    .ack_lvl  (lvl_q),
    .reti     (int_reti),
    .mask_q   (in_service),
    .rank     (rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (ack_fire) begin
      req_q <= 1'b0;
    end else begin
      req_q <= found;
      idx_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assign int_req = req_q;
  assign int_src = idx_q;

  AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q[GATE_BIT] |=> !int_req); // R2
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (RANK_W'(lvl_q) + RANK_W'(1)) > rank); // R6
  AST_TOP_LEVEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[NLVL-1] |-> !int_req); // R7
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |=> !int_req); // R8
  AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_src < IDX_W'(NSRC)); // R11

endmodule

// File: tb/test_nest_irq_arbiter.sv
`timescale 1ns/1ps
module test_nest_irq_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_pend = '0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int_req;
  logic [2:0] int_src;
  logic       int_ack = 1'b0;
  logic       int_reti = 1'b0;
  logic [3:0] in_service;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  nest_irq_arbiter i_nest_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_req(int_req), .int_src(int_src),
    .int_ack(int_ack), .int_reti(int_reti), .in_service(in_service)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // Reference: {found, idx}; rank is 0 for none, else top level + 1.
  function automatic logic [3:0] model(input logic [6:0] p, input logic [7:0] en,
                                       input logic [6:0] hi, input logic [6:0] lo,
                                       input int rank);
    if (!en[7]) return 4'd0;
    for (int l = 3; l >= 0; l--) begin
      if (l + 1 <= rank) return 4'd0;
      for (int i = 0; i < 7; i++) begin
        if (p[i] && en[i] && ((hi[i] ? 2 : 0) + (lo[i] ? 1 : 0)) == l)
          return {1'b1, 3'(i)};
      end
    end
    return 4'd0;
  endfunction

  task automatic sweep(input logic [7:0] en, input logic [6:0] hi,
                       input logic [6:0] lo, input int rank, input string req);
    wr(2'd0, en); wr(2'd1, {1'b0, hi}); wr(2'd2, {1'b0, lo});
    for (int p = 0; p < 128; p++) begin
      logic [3:0] e;
      irq_pend = 7'(p);
      tick();
      e = model(7'(p), en, hi, lo, rank);
      check(int_req == e[3] && (!e[3] || int_src == e[2:0]), req,
            {int_req, int_src}, e);
    end
    irq_pend = '0;
    tick();
  endtask

  task automatic clear_service();
    irq_pend = '0;
    repeat (4) begin int_reti = 1'b1; tick(); end
    int_reti = 1'b0;
    tick();
  endtask

  task automatic grant_level(input int l);
    wr(2'd0, 8'h81);
    wr(2'd1, (l >= 2) ? 8'h7F : 8'h00);
    wr(2'd2, (l % 2 == 1) ? 8'h7F : 8'h00);
    irq_pend = 7'h01;
    tick();
    check(int_req == 1'b1 && int_src == 3'd0, "R8 offer before ack", int_req, 1);
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
    irq_pend = '0;
    check(int_req == 1'b0, "R8 req drops after ack", int_req, 0);
    check(in_service[l] == 1'b1, "R8 level bit set", in_service, 1 << l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state and register access
    rd(2'd0, 8'h00, "R1 reset enable");
    rd(2'd1, 8'h00, "R1 reset hi");
    rd(2'd2, 8'h00, "R1 reset lo");
    check(int_req == 1'b0 && in_service == 4'd0, "R1 reset outputs", {int_req, in_service}, 0);
    wr(2'd0, 8'hA5); rd(2'd0, 8'hA5, "R1 enable readback");
    wr(2'd1, 8'hFF); rd(2'd1, 8'h7F, "R1 hi readback bit7 zero");
    wr(2'd2, 8'h3C); rd(2'd2, 8'h3C, "R1 lo readback");
    wr(2'd3, 8'hFF); rd(2'd3, 8'h00, "R1 addr3 reads zero");
    rd(2'd0, 8'hA5, "R1 addr3 write no effect");

    // R2 master gate off
    sweep(8'h7F, 7'h55, 7'h33, 0, "R2 gate off");

    // R3 R4 R5 R11 varied priorities and enables, nothing in service
    for (int c = 0; c < 4; c++) begin
      logic [6:0] hi, lo, enl;
      hi  = 7'(8'h25 ^ (c * 8'h3C));
      lo  = 7'(8'h5A ^ (c * 8'h47));
      enl = (c == 0) ? 7'h7F : 7'(8'h7F ^ (c * 8'h11));
      sweep({1'b1, enl}, hi, lo, 0, "R3 R4 R5 R11 arbitration");
    end
    sweep(8'hFF, 7'h00, 7'h00, 0, "R5 polling order one level");

    // R6 R7 with one level in service
    for (int l = 0; l < 4; l++) begin
      clear_service();
      grant_level(l);
      sweep(8'hFF, 7'(8'h4B ^ (l * 8'h19)), 7'(8'h36 ^ (l * 8'h2D)), l + 1,
            (l == 3) ? "R7 level3 lock" : "R6 strict preempt");
    end

    // R9 nested build and unwind: ext0 lvl0, tmr0 lvl1, ext1 lvl2
    clear_service();
    check(in_service == 4'd0, "R9 empty after reti", in_service, 0);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h04); wr(2'd2, 8'h02);
    for (int k = 0; k < 3; k++) begin
      irq_pend = 7'((1 << (k + 1)) - 1);
      tick();
      check(int_req && int_src == 3'(k), "R6 nested offer", int_src, k);
      int_ack = 1'b1; tick(); int_ack = 1'b0;
    end
    irq_pend = '0;
    check(in_service == 4'b0111, "R8 nested mask", in_service, 4'b0111);
    int_reti = 1'b1; tick(); int_reti = 1'b0;
    check(in_service == 4'b0011, "R9 reti clears top", in_service, 4'b0011);
    int_reti = 1'b1; tick(); int_reti = 1'b0;
    check(in_service == 4'b0001, "R9 reti clears next", in_service, 4'b0001);
    int_reti = 1'b1; tick(); int_reti = 1'b0;
    check(in_service == 4'b0000, "R9 reti clears last", in_service, 0);
    int_reti = 1'b1; tick(); int_reti = 1'b0;
    check(in_service == 4'b0000, "R9 reti on empty", in_service, 0);

    // R10 later higher request replaces offer; latency one clock
    wr(2'd1, 8'h40); wr(2'd2, 8'h00);
    irq_pend = 7'h01;
    #1;
    check(int_req == 1'b0, "R10 not yet registered", int_req, 0);
    tick();
    check(int_req && int_src == 3'd0, "R10 first offer", int_src, 0);
    irq_pend = 7'h41;
    tick();
    check(int_req && int_src == 3'd6, "R10 replaced by higher", int_src, 6);
    irq_pend = '0;
    tick();
    check(int_req == 1'b0, "R10 withdrawn", int_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule